// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register file behind an 8-bit general-purpose I/O port. It sits between a simple bus and the pin pads and holds four registers, selected by a small pointer. The input view reports the pin levels after an XOR with a per-bit inversion mask. The output register supplies the data driven onto the pads. The direction register decides which pads are driven and which are left high-impedance. A serial front end, or any other bus agent, issues one-cycle write strobes and read strobes. Read data comes back registered in the cycle after the read strobe.

Pin inputs cross into the clock domain through a two-stage synchronizer. A read of the input view loads the value it returns into a holding register and raises a one-cycle pulse. A neighbouring change-detect block can compare live pins against that held value. The pads use `pinOe` as their driver enable and `pinOut` as their data.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the output register reads 0xFF, the inversion mask reads 0x00 and the direction register reads 0xFF. `pinOe` is 0x00, `pinOut` is 0x00 and `inLatched` is 0xFF. A read of the input view sampled at the first clock edge after reset returns 0xFF, the reset value of the synchronizer.
- R2: Only the two low bits of `busAddr` select a register: 0 is the input view, 1 is the output register, 2 is the inversion mask and 3 is the direction register. Higher address bits are ignored.
- R3: A write with pointer 0 has no effect: every register, `pinOe` and `pinOut` keep their values.
- R4: Direction bit i set to 1 makes pin i an input (`pinOe[i]` = 0). Cleared to 0, it makes pin i an output (`pinOe[i]` = 1). The change appears right after the clock edge that samples the write.
- R5: `pinOut[i]` equals output register bit i when pin i is an output, and is 0 when pin i is an input.
- R6: A read of pointer 1 returns the stored output register value, whatever the pin levels are.
- R7: A read of pointer 0 returns the synchronized pin levels XOR the inversion mask, for every pin whatever its direction.
- R8: Let a pin change before clock edge k. A read sampled at edge k+1 returns the old level and a read sampled at edge k+2 returns the new level.
- R9: `rdData` loads at the clock edge that samples `rdEn` and holds its value in every cycle without a read.
- R10: A read of pointer 0 loads the returned value into `inLatched` and raises `inRdPulse` for one cycle, both at the same time as `rdData`. `inLatched` holds its value at all other times.
- R11: If a write and a read hit the same register in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | WIDTH | Asynchronous pin levels from the pads |
| busAddr | input | ADDR_W | Register pointer; low two bits used |
| wrEn | input | 1 | Write strobe, one cycle |
| wrData | input | WIDTH | Write data |
| rdEn | input | 1 | Read strobe, one cycle |
| rdData | output | WIDTH | Registered read data |
| pinOut | output | WIDTH | Pad output data, zero on input pins |
| pinOe | output | WIDTH | Pad driver enable, 1 = drive |
| inLatched | output | WIDTH | Input view captured at the last input read |
| inRdPulse | output | 1 | One-cycle pulse after each input read |

## Verification
The bench reads the input view on the edges just before and just after a pin change has crossed the synchronizer. A design with one synchronizer stage too many or too few returns the new level one read too late or too soon. It writes with pointer 0 and with high address bits set. A bank that decodes the full address, or that lets the input view be written, leaves a register or a pad enable changed. It issues a write and a read to the same register in the same cycle, which exposes a read that bypasses the new data. It also reads the output register while the pins disagree with it, which catches a mux that returns pin levels. Finally it switches pins between input and output, which shows whether `pinOut` is masked and whether the input view ignores direction.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

  typedef enum logic [1:0] {
    REG_IN  = 2'd0,
    REG_OUT = 2'd1,
    REG_POL = 2'd2,
    REG_DIR = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrOut;
    logic    wrPol;
    logic    wrDir;
    logic    rdStb;
    logic    rdIn;
    regSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_regbank_ctrl.sv
module gpio_regbank_ctrl
  import gpio_regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  output ctrlStrobes_t      strb
);

  localparam int SEL_W = 2;

  regSel_e sel;
  logic    unusedAddrBits;

  assign sel            = regSel_e'(busAddr[SEL_W-1:0]);
  assign unusedAddrBits = ^busAddr[ADDR_W-1:SEL_W];

  always_comb begin
    strb       = '0;
    strb.rdSel = sel;
    strb.rdStb = rdEn;
    strb.rdIn  = rdEn && (sel == REG_IN);
    if (wrEn) begin
      unique case (sel)
        REG_OUT: strb.wrOut = 1'b1;
        REG_POL: strb.wrPol = 1'b1;
        REG_DIR: strb.wrDir = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_regbank_dp.sv
module gpio_regbank_dp
  import gpio_regbank_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] wrData,
  input  ctrlStrobes_t     strb,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] inLatched,
  output logic             inRdPulse
);

  localparam logic [WIDTH-1:0] OUT_RST  = '1;
  localparam logic [WIDTH-1:0] POL_RST  = '0;
  localparam logic [WIDTH-1:0] DIR_RST  = '1;
  localparam logic [WIDTH-1:0] SYNC_RST = '1;
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncChain;
  logic [WIDTH-1:0] outReg, polReg, dirReg;
  logic [WIDTH-1:0] inView, rdMux;

  // pin synchronizer; stage 0 samples the pads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= SYNC_RST;
    end else begin
      syncChain[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end

  assign inView = syncChain[LAST] ^ polReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= OUT_RST;
      polReg <= POL_RST;
      dirReg <= DIR_RST;
    end else begin
      if (strb.wrOut) outReg <= wrData;
      if (strb.wrPol) polReg <= wrData;
      if (strb.wrDir) dirReg <= wrData;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      REG_IN:  rdMux = inView;
      REG_OUT: rdMux = outReg;
      REG_POL: rdMux = polReg;
      default: rdMux = dirReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData    <= '0;
      inLatched <= SYNC_RST;
      inRdPulse <= 1'b0;
    end else begin
      if (strb.rdStb) rdData <= rdMux;
      if (strb.rdIn) inLatched <= inView;
      inRdPulse <= strb.rdIn;
    end
  end

  assign pinOe  = ~dirReg;
  assign pinOut = outReg & ~dirReg;

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  pinIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic [WIDTH-1:0]  wrData,
  input  logic              rdEn,
  output logic [WIDTH-1:0]  rdData,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe,
  output logic [WIDTH-1:0]  inLatched,
  output logic              inRdPulse
);

  ctrlStrobes_t strb;

  gpio_regbank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .strb    (strb)
  );

  gpio_regbank_dp #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .wrData    (wrData),
    .strb      (strb),
    .rdData    (rdData),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .inLatched (inLatched),
    .inRdPulse (inRdPulse)
  );

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wrEn,
  input logic [WIDTH-1:0]  wrData,
  input logic              rdEn,
  input logic [WIDTH-1:0]  rdData,
  input logic [WIDTH-1:0]  pinOut,
  input logic [WIDTH-1:0]  pinOe,
  input logic [WIDTH-1:0]  inLatched,
  input logic              inRdPulse
);

  p_in_wr_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr[1:0] == 2'd0) |=> ($stable(pinOe) && $stable(pinOut)));

  p_dir_to_oe_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr[1:0] == 2'd3) |=> (pinOe == ~$past(wrData)));

  p_out_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr[1:0] == 2'd1) |=> (pinOut == ($past(wrData) & pinOe)));

  p_in_pin_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOut & ~pinOe) == '0));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  p_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && busAddr[1:0] == 2'd0) |=> (inRdPulse && inLatched == rdData));

  p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && busAddr[1:0] == 2'd0) |=> (!inRdPulse && $stable(inLatched)));

endmodule

bind gpio_regbank gpio_regbank_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .rdEn      (rdEn),
  .rdData    (rdData),
  .pinOut    (pinOut),
  .pinOe     (pinOe),
  .inLatched (inLatched),
  .inRdPulse (inRdPulse)
);

// File: tb/gpio_regbank_bench.sv
module gpio_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN;
  logic [W-1:0] pinIn, wrData, rdData, pinOut, pinOe, inLatched;
  logic [7:0] busAddr;
  logic wrEn, rdEn, inRdPulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_regbank u_gpio_regbank (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busAddr(busAddr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .pinOut(pinOut), .pinOe(pinOe), .inLatched(inLatched),
    .inRdPulse(inRdPulse)
  );

  typedef struct {
    logic [W-1:0] exp;
    string        req;
  } expItem_t;

  expItem_t sbQ[$];
  int nChecks = 0;
  int nFails  = 0;

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares read data one edge after each sampled read strobe
  initial begin
    logic issued;
    expItem_t item;
    forever begin
      @(posedge clk);
      issued = rdEn;
      @(negedge clk);
      if (issued) begin
        if (sbQ.size() == 0) begin
          nChecks++; nFails++;
          $display("FAIL R9 actual=unexpected-read expected=queued-item");
        end else begin
          item = sbQ.pop_front();
          check(item.req, rdData, item.exp);
        end
      end
    end
  end

  // drivers: entered at a falling edge, leave at the next falling edge
  task automatic busWrite(logic [7:0] a, logic [W-1:0] d);
    wrEn = 1'b1; busAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, logic [W-1:0] e, string req);
    rdEn = 1'b1; busAddr = a;
    sbQ.push_back('{e, req});
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; pinIn = 8'h00; busAddr = '0; wrEn = 1'b0; wrData = '0; rdEn = 1'b0;
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 pinOut", pinOut, 8'h00);
    check("R1 inLatched", inLatched, 8'hFF);
    check("R1 inRdPulse", {7'd0, inRdPulse}, 8'h00);
    busRead(8'h00, 8'hFF, "R1 input default");
    busRead(8'h01, 8'hFF, "R1 output default");
    busRead(8'h02, 8'h00, "R1 mask default");
    busRead(8'h03, 8'hFF, "R1 direction default");

    // R7 input view, plain then inverted
    pinIn = 8'h3C;
    idle(3);
    busRead(8'h00, 8'h3C, "R7 plain");
    busWrite(8'h02, 8'h0F);
    busRead(8'h00, 8'h33, "R7 inverted");
    check("R10 pulse", {7'd0, inRdPulse}, 8'h01);
    check("R10 latched", inLatched, 8'h33);
    idle(1);
    check("R10 pulse drop", {7'd0, inRdPulse}, 8'h00);

    // R4 / R5 direction and drive
    busWrite(8'h03, 8'hF0);
    check("R4 oe", pinOe, 8'h0F);
    check("R5 masked out", pinOut, 8'h0F);
    busWrite(8'h01, 8'hA6);
    check("R5 drive", pinOut, 8'h06);
    busRead(8'h01, 8'hA6, "R6 flop not pin");

    // R7 direction-independent input view, R10 hold
    pinIn = 8'hC3;
    idle(3);
    check("R10 hold", inLatched, 8'h33);
    busRead(8'h00, 8'hCC, "R7 output pins seen");

    // R3 input view not writable
    busWrite(8'h00, 8'h00);
    check("R3 oe", pinOe, 8'h0F);
    check("R3 out", pinOut, 8'h06);
    busRead(8'h00, 8'hCC, "R3 input");
    busRead(8'h01, 8'hA6, "R3 output");
    busRead(8'h02, 8'h0F, "R3 mask");
    busRead(8'h03, 8'hF0, "R3 direction");

    // R2 high address bits ignored
    busWrite(8'h05, 8'h5A);
    check("R2 write via alias", pinOut, 8'h0A);
    busRead(8'hFE, 8'h0F, "R2 mask alias");
    busRead(8'h0D, 8'h5A, "R2 output alias");
    busRead(8'h83, 8'hF0, "R2 direction alias");
    busRead(8'hFC, 8'hCC, "R2 input alias");
    check("R2 pulse on alias", {7'd0, inRdPulse}, 8'h01);

    // R8 synchronizer latency: change before edge k
    pinIn = 8'h00;
    @(negedge clk);
    busRead(8'h00, 8'hCC, "R8 edge k+1 old");
    busRead(8'h00, 8'h0F, "R8 edge k+2 new");

    // R11 write and read same register same cycle
    wrEn = 1'b1; rdEn = 1'b1; busAddr = 8'h01; wrData = 8'h77;
    sbQ.push_back('{8'h5A, "R11 old value"});
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    busRead(8'h01, 8'h77, "R11 new value");
    check("R5 after R11", pinOut, 8'h07);

    // R9 read data holds without reads
    pinIn = 8'hFF;
    idle(4);
    check("R9 hold", rdData, 8'h77);
    check("R10 hold idle", inLatched, 8'h0F);

    // all pins outputs
    busWrite(8'h03, 8'h00);
    check("R4 all out", pinOe, 8'hFF);
    check("R5 all out", pinOut, 8'h77);
    busRead(8'h00, 8'hF0, "R7 all outputs");

    idle(2);
    if (sbQ.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL R9 actual=%0d expected=0 pending reads", sbQ.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule